// File: doc/BRIEF.md
# Erase-Block Protection and Lock Manager

This block holds the write-protection state of a 16 Mbit, 1M x16 dual-bank flash array. Every erase block has a protection bit and a lock bit. The array has eight 4 KWord parameter blocks and thirty-one 32 KWord main blocks, which makes 39 blocks. A command port takes protect, unprotect and lock requests. Each request names its block by a 20-bit word address, and the block decodes that address to a block index.

A lock bit freezes the protection bit of its block, but only while the active-low write-protect input is driven low.

A second port qualifies a program or erase attempt. One cycle later it returns allow or reject, an error flag, and the bank the address falls in, so that a read-while-write arbiter can use the bank. A third port decodes a read address with no delay and returns the two-bit status code of that block.

The `TOP_BOOT` parameter places the parameter blocks at the top of the address space. Its default is 0, which places them at the bottom.

Top module: `blk_prot_mgr`

## Requirements
- R1: While rst_ni is low, and after it is released, every block is protected and unlocked, so every status read returns 0001h.
- R2: In the bottom-boot layout, word addresses 000000h to 007FFFh fall in parameter blocks 0 to 7, and block n spans n*1000h to n*1000h+0FFFh. Each address from 008000h upward falls in main block 7 + (address >> 15), which gives block indices 8 to 38.
- R3: A protect request (cmd_op_i = 00) sets the protection bit of the addressed block, and an unprotect request (cmd_op_i = 01) clears it. The change is visible from the clock edge that samples cmd_valid_i, and no other block changes.
- R4: While wp_n_i is low, protect and unprotect requests to a locked block are ignored. While wp_n_i is high, they act as in R3.
- R5: A lock request (cmd_op_i = 10) sets the lock bit of the addressed block at any level of wp_n_i. Only reset clears a lock bit.
- R6: rd_status_o is a combinational function of rd_addr_i and the current state. Bit 0 is the protection bit, bit 1 is the lock bit, and bits 15:2 are zero. The four possible values are 0000h, 0001h, 0002h and 0003h.
- R7: One cycle after chk_valid_i is high, chk_done_o is 1. At that point chk_allow_o = 1 and chk_err_o = 0 if the block was unprotected, and chk_allow_o = 0 and chk_err_o = 1 if it was protected. The block state used is the state before any command in the same cycle. When chk_valid_i is low, all three outputs are 0 in the next cycle.
- R8: chk_bank_o is 0 for bank A, which is word addresses 000000h to 03FFFFh (blocks 0 to 14). It is 1 for bank B, which is addresses 040000h and above (blocks 15 to 38). It carries the same latency as R7.
- R9: Command code 11 has no effect on any block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_n_i | input | 1 | Write-protect, active low; while low, a locked block's protection is frozen |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 protect, 01 unprotect, 10 lock, 11 no operation |
| cmd_addr_i | input | 20 | Word address that selects the command's block |
| chk_valid_i | input | 1 | Program/erase qualification request |
| chk_addr_i | input | 20 | Word address to be qualified |
| chk_done_o | output | 1 | Qualification result valid |
| chk_allow_o | output | 1 | Program/erase allowed |
| chk_err_o | output | 1 | Program/erase rejected, block is protected |
| chk_bank_o | output | 1 | Bank of the qualified address: 0 for A, 1 for B |
| rd_addr_i | input | 20 | Word address for the status read |
| rd_status_o | output | 16 | Status code of the addressed block |

## Verification
Commands take effect at the clock edge that samples them. The status read is combinational, so its value is compared half a cycle after that edge, together with the current read address. The qualification outputs appear one register after chk_valid_i. The bench drives each vector on a falling edge and lets one rising edge pass. It then compares all outputs on the next falling edge, using expected qualification values taken from its model state before the edge and expected status values taken after the edge. Address boundaries, both write-protect levels on locked blocks, and the no-operation code are directed. A seeded random run covers the rest.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;
  typedef enum logic [1:0] {
    OP_PROTECT   = 2'b00,
    OP_UNPROTECT = 2'b01,
    OP_LOCK      = 2'b10,
    OP_NOP       = 2'b11
  } prot_op_e;

  localparam int unsigned STATUS_W = 16;

  function automatic logic [STATUS_W-1:0] status_code(input logic prot, input logic lock);
    return {{(STATUS_W-2){1'b0}}, lock, prot};
  endfunction
endpackage

// File: rtl/blk_addr_map.sv
module blk_addr_map #(
  parameter int unsigned ADDR_W   = 20,
  parameter bit          TOP_BOOT = 1'b0,
  parameter int unsigned PAR_W    = 12,
  parameter int unsigned MAIN_W   = 15,
  parameter int unsigned N_PAR    = 8,
  parameter int unsigned N_MAIN   = 31,
  parameter int unsigned N_MAIN_A = 7,
  parameter int unsigned IDX_W    = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              bank_b_o
);
  localparam logic [ADDR_W-1:0] PAR_SPAN  = ADDR_W'(N_PAR << PAR_W);
  localparam logic [ADDR_W-1:0] MAIN_SPAN = ADDR_W'(N_MAIN << MAIN_W);
  localparam logic [IDX_W-1:0]  PAR_IN_MAIN = IDX_W'((N_PAR << PAR_W) >> MAIN_W);
  localparam logic [IDX_W-1:0]  BOT_B_FIRST = IDX_W'(N_PAR + N_MAIN_A);
  localparam logic [IDX_W-1:0]  TOP_A_FIRST = IDX_W'(N_MAIN - N_MAIN_A);

  if (TOP_BOOT) begin : g_top
    logic [ADDR_W-1:0] par_off;
    always_comb begin
      par_off = addr_i - MAIN_SPAN;
      if (addr_i < MAIN_SPAN) idx_o = IDX_W'(addr_i >> MAIN_W);
      else                    idx_o = IDX_W'(N_MAIN) + IDX_W'(par_off >> PAR_W);
      bank_b_o = (idx_o < TOP_A_FIRST);
    end
  end else begin : g_bottom
    always_comb begin
      if (addr_i < PAR_SPAN) idx_o = IDX_W'(addr_i >> PAR_W);
      else                   idx_o = IDX_W'(N_PAR) + IDX_W'(addr_i >> MAIN_W) - PAR_IN_MAIN;
      bank_b_o = (idx_o >= BOT_B_FIRST);
    end
  end
endmodule

// File: rtl/blk_state_array.sv
module blk_state_array
  import blk_prot_pkg::*;
#(
  parameter int unsigned N_BLK = 39,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wp_n_i,
  output logic [N_BLK-1:0] prot_o,
  output logic [N_BLK-1:0] lock_o
);
  prot_op_e op;
  assign op = prot_op_e'(op_i);

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    logic sel, frozen;
    assign sel    = wr_en_i && (idx_i == IDX_W'(g));
    assign frozen = lock_o[g] && !wp_n_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prot_o[g] <= 1'b1;
        lock_o[g] <= 1'b0;
      end else if (sel) begin
        unique case (op)
          OP_PROTECT:   if (!frozen) prot_o[g] <= 1'b1;
          OP_UNPROTECT: if (!frozen) prot_o[g] <= 1'b0;
          OP_LOCK:      lock_o[g] <= 1'b1;
          default:      ;
        endcase
      end
    end
  end
endmodule

// File: rtl/blk_check_stage.sv
module blk_check_stage #(
  parameter int unsigned N_BLK = 39,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bank_b_i,
  input  logic [N_BLK-1:0] prot_i,
  output logic             done_o,
  output logic             allow_o,
  output logic             err_o,
  output logic             bank_o
);
  logic hit_prot;
  assign hit_prot = prot_i[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      allow_o <= 1'b0;
      err_o   <= 1'b0;
      bank_o  <= 1'b0;
    end else begin
      done_o  <= valid_i;
      allow_o <= valid_i && !hit_prot;
      err_o   <= valid_i && hit_prot;
      bank_o  <= valid_i && bank_b_i;
    end
  end
endmodule

// File: rtl/blk_prot_mgr.sv
module blk_prot_mgr
  import blk_prot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter bit          TOP_BOOT = 1'b0,
  parameter int unsigned PAR_W    = 12,
  parameter int unsigned MAIN_W   = 15,
  parameter int unsigned N_PAR    = 8,
  parameter int unsigned N_MAIN   = 31,
  parameter int unsigned N_MAIN_A = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_n_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              chk_valid_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_done_o,
  output logic              chk_allow_o,
  output logic              chk_err_o,
  output logic              chk_bank_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_status_o
);
  localparam int unsigned N_BLK = N_PAR + N_MAIN;
  localparam int unsigned IDX_W = $clog2(N_BLK);
  localparam int unsigned N_PORT = 3;  // 0 command, 1 check, 2 read

  logic [N_PORT-1:0][ADDR_W-1:0] port_addr;
  logic [N_PORT-1:0][IDX_W-1:0]  port_idx;
  logic [N_PORT-1:0]             port_bank;
  logic [N_BLK-1:0]              prot_q, lock_q;

  assign port_addr[0] = cmd_addr_i;
  assign port_addr[1] = chk_addr_i;
  assign port_addr[2] = rd_addr_i;

  for (genvar p = 0; p < N_PORT; p++) begin : g_map
    blk_addr_map #(
      .ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT), .PAR_W(PAR_W), .MAIN_W(MAIN_W),
      .N_PAR(N_PAR), .N_MAIN(N_MAIN), .N_MAIN_A(N_MAIN_A), .IDX_W(IDX_W)
    ) u_map (
      .addr_i  (port_addr[p]),
      .idx_o   (port_idx[p]),
      .bank_b_o(port_bank[p])
    );
  end

  blk_state_array #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(cmd_valid_i),
    .op_i   (cmd_op_i),
    .idx_i  (port_idx[0]),
    .wp_n_i (wp_n_i),
    .prot_o (prot_q),
    .lock_o (lock_q)
  );

  blk_check_stage #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_chk_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (chk_valid_i),
    .idx_i   (port_idx[1]),
    .bank_b_i(port_bank[1]),
    .prot_i  (prot_q),
    .done_o  (chk_done_o),
    .allow_o (chk_allow_o),
    .err_o   (chk_err_o),
    .bank_o  (chk_bank_o)
  );

  assign rd_status_o = status_code(prot_q[port_idx[2]], lock_q[port_idx[2]]);

  logic unused_rd_bank;
  assign unused_rd_bank = port_bank[0] ^ port_bank[2];
endmodule

// File: rtl/blk_prot_mgr_chk.sv
module blk_prot_mgr_chk #(
  parameter int unsigned N_BLK = 39
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wp_n_i,
  input logic             chk_valid_i,
  input logic             chk_done_o,
  input logic             chk_allow_o,
  input logic             chk_err_o,
  input logic [15:0]      rd_status_o,
  input logic [N_BLK-1:0] prot_q,
  input logic [N_BLK-1:0] lock_q
);
  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(lock_q) & ~lock_q) == '0));

  a_r4_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wp_n_i) |-> (((prot_q ^ $past(prot_q)) & $past(lock_q)) == '0));

  a_r3_one_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(prot_q ^ $past(prot_q)) + $countones(lock_q ^ $past(lock_q))) <= 1);

  a_r7_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> chk_done_o);

  a_r7_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |-> (chk_allow_o != chk_err_o));

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_done_o |-> !(chk_allow_o || chk_err_o));

  a_r6_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_o[15:2] == '0);
endmodule

bind blk_prot_mgr blk_prot_mgr_chk #(.N_BLK(N_BLK)) u_prot_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_n_i     (wp_n_i),
  .chk_valid_i(chk_valid_i),
  .chk_done_o (chk_done_o),
  .chk_allow_o(chk_allow_o),
  .chk_err_o  (chk_err_o),
  .rd_status_o(rd_status_o),
  .prot_q     (prot_q),
  .lock_q     (lock_q)
);

// File: tb/sim_blk_prot_mgr.sv
`timescale 1ns/1ps
module sim_blk_prot_mgr;
  localparam int NB = 39;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wp_n_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b11;
  logic [19:0] cmd_addr_i = '0;
  logic        chk_valid_i = 1'b0;
  logic [19:0] chk_addr_i = '0;
  logic        chk_done_o, chk_allow_o, chk_err_o, chk_bank_o;
  logic [19:0] rd_addr_i = '0;
  logic [15:0] rd_status_o;

  int n_vec = 0;
  int n_bad = 0;
  bit m_prot[NB];
  bit m_lock[NB];

  always #4 clk = ~clk;

  blk_prot_mgr u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wp_n_i(wp_n_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i),
    .chk_valid_i(chk_valid_i), .chk_addr_i(chk_addr_i),
    .chk_done_o(chk_done_o), .chk_allow_o(chk_allow_o), .chk_err_o(chk_err_o),
    .chk_bank_o(chk_bank_o), .rd_addr_i(rd_addr_i), .rd_status_o(rd_status_o)
  );

  // R2 expected map
  function automatic int ref_idx(input logic [19:0] a);
    if (a <= 20'h07FFF) return int'(a) / 4096;
    return 7 + int'(a) / 32768;
  endfunction

  // R8 expected bank
  function automatic bit ref_bank(input logic [19:0] a);
    return a >= 20'h40000;
  endfunction

  function automatic logic [19:0] blk_addr(input int k, input int off);
    if (k < 8) return 20'(k * 4096 + (off % 4096));
    return 20'((k - 7) * 32768 + (off % 32768));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One vector: drive at negedge, edge, compare at next negedge.
  task automatic step(input bit cv, input logic [1:0] op, input logic [19:0] ca,
                      input bit wp, input bit kv, input logic [19:0] ka,
                      input logic [19:0] ra, input string req);
    bit e_prot, e_bank;
    int k;
    cmd_valid_i = cv; cmd_op_i = op; cmd_addr_i = ca; wp_n_i = wp;
    chk_valid_i = kv; chk_addr_i = ka; rd_addr_i = ra;
    e_prot = m_prot[ref_idx(ka)];
    e_bank = ref_bank(ka);
    @(posedge clk);
    if (cv) begin
      k = ref_idx(ca);
      case (op)
        2'b00: if (!(m_lock[k] && !wp)) m_prot[k] = 1'b1;
        2'b01: if (!(m_lock[k] && !wp)) m_prot[k] = 1'b0;
        2'b10: m_lock[k] = 1'b1;
        default: ;
      endcase
    end
    @(negedge clk);
    check({req, " done R7"}, 32'(chk_done_o), 32'(kv));
    if (kv) begin
      check({req, " allow R7"}, 32'(chk_allow_o), 32'(!e_prot));
      check({req, " err R7"}, 32'(chk_err_o), 32'(e_prot));
      check({req, " bank R8"}, 32'(chk_bank_o), 32'(e_bank));
    end
    check({req, " status R6"}, 32'(rd_status_o),
          32'({m_lock[ref_idx(ra)], m_prot[ref_idx(ra)]}));
  endtask

  task automatic rd(input logic [19:0] a, input string req);
    step(1'b0, 2'b11, 20'h0, 1'b1, 1'b0, 20'h0, a, req);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) begin m_prot[i] = 1'b1; m_lock[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 reset done", 32'(chk_done_o), 32'd0);
    check("R1 reset status", 32'(rd_status_o), 32'h0001);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: all blocks protected and unlocked
    for (int k = 0; k < NB; k++) rd(blk_addr(k, 17), "R1");

    // R2/R3: unprotect last word of parameter block 7, neighbours untouched
    step(1'b1, 2'b01, 20'h07FFF, 1'b1, 1'b0, 20'h0, 20'h07000, "R3 unprot p7");
    rd(20'h08000, "R2 main first");
    rd(20'h06FFF, "R2 p6 last");
    step(1'b1, 2'b01, 20'h08000, 1'b1, 1'b1, 20'h08000, 20'h0FFFF, "R3 unprot b8");
    step(1'b0, 2'b11, 20'h0, 1'b1, 1'b1, 20'h08123, 20'h08000, "R7 after unprot");
    // R8 bank boundary
    step(1'b0, 2'b11, 20'h0, 1'b1, 1'b1, 20'h3FFFF, 20'h3FFFF, "R8 bank A last");
    step(1'b0, 2'b11, 20'h0, 1'b1, 1'b1, 20'h40000, 20'h40000, "R8 bank B first");
    step(1'b0, 2'b11, 20'h0, 1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF, "R2 top block");
    // R5 lock with wp low, R4 frozen
    step(1'b1, 2'b10, 20'h07000, 1'b0, 1'b0, 20'h0, 20'h07000, "R5 lock wp low");
    step(1'b1, 2'b00, 20'h07000, 1'b0, 1'b1, 20'h07000, 20'h07000, "R4 protect frozen");
    step(1'b1, 2'b00, 20'h07000, 1'b1, 1'b0, 20'h0, 20'h07000, "R4 protect wp high");
    step(1'b1, 2'b01, 20'h07000, 1'b0, 1'b0, 20'h0, 20'h07000, "R4 unprot frozen");
    step(1'b1, 2'b01, 20'h07000, 1'b1, 1'b0, 20'h0, 20'h07000, "R4 unprot wp high");
    // R5 lock on protected block with wp high
    step(1'b1, 2'b10, 20'h20000, 1'b1, 1'b0, 20'h0, 20'h20000, "R5 lock wp high");
    // R9 no-op
    step(1'b1, 2'b11, 20'h00000, 1'b1, 1'b0, 20'h0, 20'h00000, "R9 nop");
    step(1'b1, 2'b11, 20'h07000, 1'b0, 1'b0, 20'h0, 20'h07000, "R9 nop locked");
    // R7: check uses state before same-cycle command
    step(1'b1, 2'b01, 20'h50000, 1'b1, 1'b1, 20'h50000, 20'h50000, "R7 same cycle");

    // random
    for (int i = 0; i < 3000; i++) begin
      int kc, kk, kr;
      logic [1:0] op;
      kc = int'($urandom_range(NB - 1));
      kk = int'($urandom_range(NB - 1));
      kr = ($urandom_range(1) == 1) ? kc : int'($urandom_range(NB - 1));
      op = ($urandom_range(9) == 0) ? 2'b11 : (($urandom_range(7) == 0) ? 2'b10 : 2'($urandom_range(1)));
      step(1'($urandom_range(3) != 0), op, blk_addr(kc, int'($urandom)),
           1'($urandom_range(1)), 1'($urandom_range(1)),
           blk_addr(kk, int'($urandom)), blk_addr(kr, int'($urandom)), "R3 rand");
    end

    // R5: reset clears locks
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NB; i++) begin m_prot[i] = 1'b1; m_lock[i] = 1'b0; end
    @(negedge clk);
    rd(20'h07000, "R5 reset clears lock");
    rd(20'h20000, "R1 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule